// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block is the control slice of a small 32-bit processor core that steers the program counter into a handler whenever a reset-class event, a synchronous exception (general fault, translation miss or trap instruction) or an external interrupt must be taken. It owns the program counter redirect, the vector base, the status word, the three save registers (saved PC, saved status, saved stack pointer), the three event-code registers (exception cause, interrupt cause, trap immediate) and a floating-point control word that only takes its reset value. It also owns two copies of the low eight general registers. The copy that software sees is picked by the status word's privilege and bank bits.

Each cycle the core presents its current PC and R15, a flag that marks a branch delay slot, and any event requests. One event is accepted per cycle, in a fixed priority order. All state it changes is visible on the outputs the next cycle, and `redirect` pulses for that one cycle so that fetch restarts at `pc`. When no event is accepted, the core may write the status word or the vector base through dedicated write ports. A small port reads and writes the eight low registers.

Top module: `exc_entry_seq`

## Requirements
- R1: After `rst_n` low, `pc`=0xA0000000, `npc`=0xA0000002, `vbr`=0, `sr`=0x700000F0, `fpscr`=0x00040001, and `redirect`, the save registers, the event codes and all sixteen low registers are 0.
- R2: A general exception (`exc_kind`=0 or 3) causes these updates one cycle later. `redirect` is 1. `spc` takes `cur_pc`, `ssr` takes the old `sr`, `sgr` takes `cur_r15` and `expevt` takes `exc_code`. `pc` becomes `vbr`+0x100 and `npc` becomes `pc`+2.
- R3: For an exception or trap with `in_dslot`=1, `spc` takes `cur_pc`-2.
- R4: Every accepted exception, trap or interrupt sets `sr` to the old `sr` with bits 30 (privilege), 29 (bank) and 28 (block) forced to 1. All other bits are unchanged.
- R5: A translation-miss exception (`exc_kind`=1) behaves like R2 but jumps to `vbr`+0x400.
- R6: A trap (`exc_kind`=2) sets `tra` to `trap_imm`<<2 (zero-extended) and `expevt` to 0x160. It then follows the general path (vector 0x100).
- R7: An accepted interrupt sets `intevt` to `irq_code` and leaves `expevt` unchanged. `spc` takes `cur_pc` with no delay-slot adjustment. `ssr` and `sgr` are saved as in R2, and `pc` becomes `vbr`+0x600.
- R8: `irq_req` is ignored while `sr` bit 28 is 1. In that case there is no redirect and no state change.
- R9: Priority is reset-class, then exception/trap, then interrupt. An `sr_we` or `vbr_we` in a cycle that accepts an event is dropped.
- R10: A reset-class request (`rst_req`) causes these updates. `vbr` becomes 0, `pc` becomes 0xA0000000, `npc` becomes 0xA0000002 and `expevt` takes `rst_code`. `sr` becomes (old `sr` | bits 30,29,28,7:4) with bit 15 cleared. `redirect` is 1, and `spc`, `ssr` and `sgr` are unchanged.
- R11: The effective bank is `sr`[30] & `sr`[29]. The register port accesses R0–R7 of the bank that is active in the current cycle. When the effective bank changes through any `sr` update, the visible R0–R7 are exchanged with the other copy.
- R12: With no event accepted, `sr_we` loads `sr_wdata` into `sr` and `vbr_we` loads `vbr_wdata` into `vbr`, both visible the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| rst_req | input | 1 | Reset-class event request |
| rst_code | input | CODE_W | Cause code for the reset-class event |
| exc_req | input | 1 | Synchronous exception or trap request |
| exc_kind | input | 2 | 0 general, 1 translation miss, 2 trap, 3 general |
| exc_code | input | CODE_W | Exception cause code |
| trap_imm | input | 8 | Trap instruction immediate |
| irq_req | input | 1 | Interrupt request from the arbiter |
| irq_code | input | CODE_W | Accepted interrupt cause code |
| cur_pc | input | 32 | PC of the faulting or interrupted instruction |
| cur_r15 | input | 32 | Current stack pointer |
| in_dslot | input | 1 | Fault occurred in a branch delay slot |
| sr_we | input | 1 | Status word write |
| sr_wdata | input | 32 | Status word write data |
| vbr_we | input | 1 | Vector base write |
| vbr_wdata | input | 32 | Vector base write data |
| gr_we | input | 1 | Low register write |
| gr_widx | input | 3 | Low register write index |
| gr_wdata | input | 32 | Low register write data |
| gr_ridx | input | 3 | Low register read index |
| gr_rdata | output | 32 | Low register read data, active bank |
| redirect | output | 1 | One-cycle pulse: fetch from `pc` |
| pc | output | 32 | Redirect target |
| npc | output | 32 | Redirect target plus 2 |
| vbr | output | 32 | Vector base |
| sr | output | 32 | Status word |
| fpscr | output | 32 | Floating-point control word |
| spc | output | 32 | Saved PC |
| ssr | output | 32 | Saved status word |
| sgr | output | 32 | Saved stack pointer |
| expevt | output | CODE_W | Exception cause |
| intevt | output | CODE_W | Interrupt cause |
| tra | output | 32 | Trap immediate times four |

## Verification
Directed sequences drive each event class one at a time. These show whether the vector offset, the choice among the cause registers and the delay-slot wind-back are all decided by the event class. Status words that flip the privilege/bank pair are mixed with register writes, so an exchange of the low registers shows up at the read port as data from the other copy. Simultaneous requests, and an interrupt that arrives while the block bit is set, separate a correct priority and masking from a design that lets a lower class through. A long stretch of random requests and writes is then compared every cycle against a behavioural model that physically swaps its two register arrays.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int XLEN   = 32;
    localparam int SR_MD  = 30;
    localparam int SR_RB  = 29;
    localparam int SR_BL  = 28;
    localparam int SR_FD  = 15;
    localparam logic [XLEN-1:0] ENTRY_SET = (32'h1 << SR_MD) | (32'h1 << SR_RB) | (32'h1 << SR_BL);
    localparam logic [XLEN-1:0] IMASK_SET = 32'h0000_00F0;

    typedef enum logic [1:0] {EK_GEN = 2'd0, EK_TLB = 2'd1, EK_TRAP = 2'd2, EK_GEN2 = 2'd3} exc_kind_e;
    typedef enum logic [1:0] {EV_NONE = 2'd0, EV_RESET = 2'd1, EV_EXC = 2'd2, EV_IRQ = 2'd3} ev_e;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] npc;
        logic [XLEN-1:0] vbr;
        logic [XLEN-1:0] sr;
        logic [XLEN-1:0] fpscr;
        logic [XLEN-1:0] spc;
        logic [XLEN-1:0] ssr;
        logic [XLEN-1:0] sgr;
        logic [XLEN-1:0] tra;
        logic            redirect;
    } seq_state_t;
endpackage

// File: rtl/exc_vec_sel.sv
module exc_vec_sel
    import exc_pkg::*;
#(
    parameter logic [XLEN-1:0] GEN_OFF = 32'h100,
    parameter logic [XLEN-1:0] TLB_OFF = 32'h400,
    parameter logic [XLEN-1:0] IRQ_OFF = 32'h600
) (
    input  logic [XLEN-1:0] vbr_i,
    input  ev_e             ev_i,
    input  logic [1:0]      kind_i,
    output logic [XLEN-1:0] target_o
);
    logic [XLEN-1:0] off;

    always_comb begin
        case (ev_i)
            EV_IRQ:  off = IRQ_OFF;
            EV_EXC:  off = (kind_i == EK_TLB) ? TLB_OFF : GEN_OFF;
            default: off = GEN_OFF;
        endcase
        target_o = vbr_i + off;
    end
endmodule

// File: rtl/exc_bank_regs.sv
module exc_bank_regs
    import exc_pkg::*;
#(
    parameter int NREG  = 8,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bank_i,
    input  logic             we_i,
    input  logic [IDX_W-1:0] widx_i,
    input  logic [XLEN-1:0]  wdata_i,
    input  logic [IDX_W-1:0] ridx_i,
    output logic [XLEN-1:0]  rdata_o
);
    logic [1:0][NREG-1:0][XLEN-1:0] bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (we_i) begin
            bank_d[bank_i][widx_i] = wdata_i;
        end
        rdata_o = bank_q[bank_i][ridx_i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int                CODE_W      = 12,
    parameter int                NREG        = 8,
    parameter logic [CODE_W-1:0] TRAP_CODE   = 12'h160,
    parameter logic [31:0]       GEN_OFF     = 32'h100,
    parameter logic [31:0]       TLB_OFF     = 32'h400,
    parameter logic [31:0]       IRQ_OFF     = 32'h600,
    parameter logic [31:0]       RESET_PC    = 32'hA000_0000,
    parameter logic [31:0]       RESET_SR    = 32'h7000_00F0,
    parameter logic [31:0]       RESET_FPSCR = 32'h0004_0001
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rst_req,
    input  logic [CODE_W-1:0]         rst_code,
    input  logic                      exc_req,
    input  logic [1:0]                exc_kind,
    input  logic [CODE_W-1:0]         exc_code,
    input  logic [7:0]                trap_imm,
    input  logic                      irq_req,
    input  logic [CODE_W-1:0]         irq_code,
    input  logic [31:0]               cur_pc,
    input  logic [31:0]               cur_r15,
    input  logic                      in_dslot,
    input  logic                      sr_we,
    input  logic [31:0]               sr_wdata,
    input  logic                      vbr_we,
    input  logic [31:0]               vbr_wdata,
    input  logic                      gr_we,
    input  logic [$clog2(NREG)-1:0]   gr_widx,
    input  logic [31:0]               gr_wdata,
    input  logic [$clog2(NREG)-1:0]   gr_ridx,
    output logic [31:0]               gr_rdata,
    output logic                      redirect,
    output logic [31:0]               pc,
    output logic [31:0]               npc,
    output logic [31:0]               vbr,
    output logic [31:0]               sr,
    output logic [31:0]               fpscr,
    output logic [31:0]               spc,
    output logic [31:0]               ssr,
    output logic [31:0]               sgr,
    output logic [CODE_W-1:0]         expevt,
    output logic [CODE_W-1:0]         intevt,
    output logic [31:0]               tra
);
    seq_state_t        st_d, st_q;
    logic [CODE_W-1:0] expevt_d, expevt_q;
    logic [CODE_W-1:0] intevt_d, intevt_q;
    ev_e               ev;
    logic [XLEN-1:0]   target;
    logic              bank_sel;

    // Event selection: reset-class wins, then exception/trap, then unmasked interrupt
    always_comb begin
        if (rst_req) begin
            ev = EV_RESET;
        end else if (exc_req) begin
            ev = EV_EXC;
        end else if (irq_req && !st_q.sr[SR_BL]) begin
            ev = EV_IRQ;
        end else begin
            ev = EV_NONE;
        end
    end

    exc_vec_sel #(
        .GEN_OFF (GEN_OFF),
        .TLB_OFF (TLB_OFF),
        .IRQ_OFF (IRQ_OFF)
    ) u_vec (
        .vbr_i    (st_q.vbr),
        .ev_i     (ev),
        .kind_i   (exc_kind),
        .target_o (target)
    );

    always_comb begin
        st_d          = st_q;
        expevt_d      = expevt_q;
        intevt_d      = intevt_q;
        st_d.redirect = 1'b0;
        case (ev)
            EV_RESET: begin
                st_d.vbr      = '0;
                st_d.pc       = RESET_PC;
                st_d.npc      = RESET_PC + 32'd2;
                st_d.sr       = (st_q.sr | ENTRY_SET | IMASK_SET) & ~(32'h1 << SR_FD);
                expevt_d      = rst_code;
                st_d.redirect = 1'b1;
            end
            EV_EXC: begin
                st_d.spc      = in_dslot ? (cur_pc - 32'd2) : cur_pc;
                st_d.ssr      = st_q.sr;
                st_d.sgr      = cur_r15;
                st_d.pc       = target;
                st_d.npc      = target + 32'd2;
                st_d.sr       = st_q.sr | ENTRY_SET;
                st_d.redirect = 1'b1;
                if (exc_kind == EK_TRAP) begin
                    st_d.tra = {{(XLEN-10){1'b0}}, trap_imm, 2'b00};
                    expevt_d = TRAP_CODE;
                end else begin
                    expevt_d = exc_code;
                end
            end
            EV_IRQ: begin
                st_d.spc      = cur_pc;
                st_d.ssr      = st_q.sr;
                st_d.sgr      = cur_r15;
                st_d.pc       = target;
                st_d.npc      = target + 32'd2;
                st_d.sr       = st_q.sr | ENTRY_SET;
                intevt_d      = irq_code;
                st_d.redirect = 1'b1;
            end
            default: begin
                if (sr_we) begin
                    st_d.sr = sr_wdata;
                end
                if (vbr_we) begin
                    st_d.vbr = vbr_wdata;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.pc       <= RESET_PC;
            st_q.npc      <= RESET_PC + 32'd2;
            st_q.sr       <= RESET_SR;
            st_q.fpscr    <= RESET_FPSCR;
            expevt_q      <= '0;
            intevt_q      <= '0;
        end else begin
            st_q          <= st_d;
            expevt_q      <= expevt_d;
            intevt_q      <= intevt_d;
        end
    end

    // Indexing by the effective bank is equivalent to exchanging the copies on every change
    assign bank_sel = st_q.sr[SR_MD] & st_q.sr[SR_RB];

    exc_bank_regs #(
        .NREG (NREG)
    ) u_banks (
        .clk     (clk),
        .rst_n   (rst_n),
        .bank_i  (bank_sel),
        .we_i    (gr_we),
        .widx_i  (gr_widx),
        .wdata_i (gr_wdata),
        .ridx_i  (gr_ridx),
        .rdata_o (gr_rdata)
    );

    assign redirect = st_q.redirect;
    assign pc       = st_q.pc;
    assign npc      = st_q.npc;
    assign vbr      = st_q.vbr;
    assign sr       = st_q.sr;
    assign fpscr    = st_q.fpscr;
    assign spc      = st_q.spc;
    assign ssr      = st_q.ssr;
    assign sgr      = st_q.sgr;
    assign tra      = st_q.tra;
    assign expevt   = expevt_q;
    assign intevt   = intevt_q;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
    parameter int          CODE_W   = 12,
    parameter logic [31:0] IRQ_OFF  = 32'h600,
    parameter logic [31:0] RESET_PC = 32'hA000_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rst_req,
    input logic              exc_req,
    input logic              irq_req,
    input logic [CODE_W-1:0] irq_code,
    input logic [31:0]       cur_pc,
    input logic [31:0]       cur_r15,
    input logic              in_dslot,
    input logic              redirect,
    input logic [31:0]       pc,
    input logic [31:0]       npc,
    input logic [31:0]       vbr,
    input logic [31:0]       sr,
    input logic [31:0]       spc,
    input logic [31:0]       ssr,
    input logic [31:0]       sgr,
    input logic [CODE_W-1:0] intevt
);
    a_r1_npc_follows: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> (npc == pc + 32'd2));

    a_r2_saves: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && !rst_req) |=> (redirect && sgr == $past(cur_r15) && ssr == $past(sr)));

    a_r3_dslot_back: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && !rst_req && in_dslot) |=> (spc == $past(cur_pc) - 32'd2));

    a_r4_entry_bits: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> (sr[30:28] == 3'b111));

    a_r7_irq_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !sr[28] && !rst_req && !exc_req) |=>
            (intevt == $past(irq_code) && pc == vbr + IRQ_OFF && spc == $past(cur_pc)));

    a_r8_blocked_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && sr[28] && !rst_req && !exc_req) |=> !redirect);

    a_r10_reset_class: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> (pc == RESET_PC && vbr == 32'd0 && sr[7:4] == 4'hF && !sr[15]
                     && $stable(ssr) && $stable(sgr)));
endmodule

bind exc_entry_seq exc_entry_chk #(
    .CODE_W   (CODE_W),
    .IRQ_OFF  (IRQ_OFF),
    .RESET_PC (RESET_PC)
) u_chk (.*);

// File: tb/test_exc_entry_seq.sv
module test_exc_entry_seq;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        rst_req, exc_req, irq_req, in_dslot, sr_we, vbr_we, gr_we;
    logic [11:0] rst_code, exc_code, irq_code;
    logic [1:0]  exc_kind;
    logic [7:0]  trap_imm;
    logic [31:0] cur_pc, cur_r15, sr_wdata, vbr_wdata, gr_wdata;
    logic [2:0]  gr_widx, gr_ridx;
    logic [31:0] gr_rdata, pc, npc, vbr, sr, fpscr, spc, ssr, sgr, tra;
    logic        redirect;
    logic [11:0] expevt, intevt;

    always #5 clk = ~clk;

    exc_entry_seq i_exc_entry_seq (
        .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .rst_code(rst_code),
        .exc_req(exc_req), .exc_kind(exc_kind), .exc_code(exc_code), .trap_imm(trap_imm),
        .irq_req(irq_req), .irq_code(irq_code), .cur_pc(cur_pc), .cur_r15(cur_r15),
        .in_dslot(in_dslot), .sr_we(sr_we), .sr_wdata(sr_wdata), .vbr_we(vbr_we),
        .vbr_wdata(vbr_wdata), .gr_we(gr_we), .gr_widx(gr_widx), .gr_wdata(gr_wdata),
        .gr_ridx(gr_ridx), .gr_rdata(gr_rdata), .redirect(redirect), .pc(pc), .npc(npc),
        .vbr(vbr), .sr(sr), .fpscr(fpscr), .spc(spc), .ssr(ssr), .sgr(sgr),
        .expevt(expevt), .intevt(intevt), .tra(tra)
    );

    int    errors = 0;
    int    checks = 0;
    string cur_req = "R1";
    string chk_req = "R1";
    logic  started = 1'b0;

    // Behavioural reference: two arrays physically exchanged on a bank change
    logic [31:0] m_act [8];
    logic [31:0] m_oth [8];
    logic [31:0] m_pc, m_npc, m_vbr, m_sr, m_spc, m_ssr, m_sgr, m_tra;
    logic [11:0] m_exp, m_int;
    logic        m_redir;

    always @(posedge clk) begin
        logic [31:0] old_sr, new_sr, base;
        chk_req = cur_req;
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) begin m_act[i] = 0; m_oth[i] = 0; end
            m_pc = 32'hA000_0000; m_npc = 32'hA000_0002; m_vbr = 0; m_sr = 32'h7000_00F0;
            m_spc = 0; m_ssr = 0; m_sgr = 0; m_tra = 0; m_exp = 0; m_int = 0; m_redir = 0;
        end else begin
            old_sr = m_sr; new_sr = old_sr; m_redir = 0;
            if (gr_we) m_act[gr_widx] = gr_wdata;
            if (rst_req) begin
                m_vbr = 0; m_pc = 32'hA000_0000; m_npc = 32'hA000_0002; m_exp = rst_code;
                new_sr = (old_sr | 32'h7000_00F0) & ~32'h0000_8000; m_redir = 1;
            end else if (exc_req) begin
                m_spc = in_dslot ? cur_pc - 2 : cur_pc; m_ssr = old_sr; m_sgr = cur_r15;
                base = (exc_kind == 2'd1) ? 32'h400 : 32'h100;
                m_pc = m_vbr + base; m_npc = m_pc + 2; new_sr = old_sr | 32'h7000_0000; m_redir = 1;
                if (exc_kind == 2'd2) begin m_tra = {22'd0, trap_imm, 2'b00}; m_exp = 12'h160; end
                else m_exp = exc_code;
            end else if (irq_req && !old_sr[28]) begin
                m_spc = cur_pc; m_ssr = old_sr; m_sgr = cur_r15; m_int = irq_code;
                m_pc = m_vbr + 32'h600; m_npc = m_pc + 2; new_sr = old_sr | 32'h7000_0000; m_redir = 1;
            end else begin
                if (sr_we) new_sr = sr_wdata;
                if (vbr_we) m_vbr = vbr_wdata;
            end
            if ((old_sr[30] & old_sr[29]) != (new_sr[30] & new_sr[29])) begin
                for (int i = 0; i < 8; i++) begin
                    logic [31:0] t;
                    t = m_act[i]; m_act[i] = m_oth[i]; m_oth[i] = t;
                end
            end
            m_sr = new_sr;
        end
    end

    task automatic chk(input string nm, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", chk_req, nm, act, exp);
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (started) begin
            chk("redirect", {31'd0, redirect}, {31'd0, m_redir});
            chk("pc", pc, m_pc);
            chk("npc", npc, m_npc);
            chk("vbr", vbr, m_vbr);
            chk("sr", sr, m_sr);
            chk("fpscr", fpscr, 32'h0004_0001);
            chk("spc", spc, m_spc);
            chk("ssr", ssr, m_ssr);
            chk("sgr", sgr, m_sgr);
            chk("tra", tra, m_tra);
            chk("expevt", {20'd0, expevt}, {20'd0, m_exp});
            chk("intevt", {20'd0, intevt}, {20'd0, m_int});
            chk("gr_rdata", gr_rdata, m_act[gr_ridx]);
        end
    end

    task automatic idle();
        rst_req = 0; exc_req = 0; irq_req = 0; sr_we = 0; vbr_we = 0; gr_we = 0;
        in_dslot = 0; exc_kind = 0; trap_imm = 0;
    endtask

    task automatic tick(input string tag);
        @(negedge clk);
        cur_req = tag;
    endtask

    initial begin
        rst_n = 0; idle();
        rst_code = 0; exc_code = 0; irq_code = 0; cur_pc = 32'h8C00_0000; cur_r15 = 0;
        sr_wdata = 0; vbr_wdata = 0; gr_wdata = 0; gr_widx = 0; gr_ridx = 0;
        repeat (3) @(negedge clk);
        rst_n = 1; started = 1'b1;
        tick("R1"); tick("R1");
        // R11: fill bank 1 (active after reset), then flip to bank 0 and fill it
        for (int i = 0; i < 8; i++) begin
            tick("R11"); idle(); gr_we = 1; gr_widx = 3'(i); gr_wdata = 32'h1000 + i; gr_ridx = 3'(i);
        end
        tick("R12"); idle(); sr_we = 1; sr_wdata = 32'h0000_0000; vbr_we = 1; vbr_wdata = 32'h8C00_0000;
        for (int i = 0; i < 8; i++) begin
            tick("R11"); idle(); gr_we = 1; gr_widx = 3'(i); gr_wdata = 32'h2000 + i; gr_ridx = 3'(7 - i);
        end
        tick("R11"); idle(); sr_we = 1; sr_wdata = 32'h6000_0000;
        for (int i = 0; i < 8; i++) begin tick("R11"); idle(); gr_ridx = 3'(i); end
        tick("R12"); idle(); sr_we = 1; sr_wdata = 32'h0000_0301;
        // R2 general exception
        tick("R2"); idle(); exc_req = 1; exc_kind = 2'd0; exc_code = 12'h1E0;
        cur_pc = 32'h8C00_1000; cur_r15 = 32'h8CFF_FF00;
        tick("R4"); idle(); gr_ridx = 3'd2;
        tick("R12"); idle(); sr_we = 1; sr_wdata = 32'h0000_0000;
        // R3 and R5: translation miss in a delay slot
        tick("R5"); idle(); exc_req = 1; exc_kind = 2'd1; exc_code = 12'h040; in_dslot = 1;
        cur_pc = 32'h8C00_2004; cur_r15 = 32'h1234_5678;
        tick("R3"); idle(); sr_we = 1; sr_wdata = 32'h0000_0000;
        // R6 trap
        tick("R6"); idle(); exc_req = 1; exc_kind = 2'd2; trap_imm = 8'hA5; cur_pc = 32'h8C00_3000;
        tick("R6"); idle(); sr_we = 1; sr_wdata = 32'h0000_00A0;
        // R7 interrupt, with a same-cycle SR write that must be dropped (R9)
        tick("R7"); idle(); irq_req = 1; irq_code = 12'h320; in_dslot = 1; cur_pc = 32'h8C00_4002;
        sr_we = 1; sr_wdata = 32'hFFFF_FFFF;
        // R8 interrupt while blocked
        tick("R8"); idle(); irq_req = 1; irq_code = 12'h340; cur_pc = 32'h8C00_5000;
        tick("R8"); idle(); irq_req = 1; irq_code = 12'h360;
        tick("R8"); idle();
        // R9 exception beats interrupt; reset-class beats both
        tick("R9"); idle(); sr_we = 1; sr_wdata = 32'h0000_0000;
        tick("R9"); idle(); exc_req = 1; exc_code = 12'h0E0; irq_req = 1; irq_code = 12'h200;
        tick("R9"); idle(); sr_we = 1; sr_wdata = 32'h0000_0000;
        tick("R9"); idle(); rst_req = 1; rst_code = 12'h020; exc_req = 1; irq_req = 1; vbr_we = 1; vbr_wdata = 32'h55;
        // R10 reset-class from a status word with FD set
        tick("R10"); idle(); sr_we = 1; sr_wdata = 32'h0000_8003;
        tick("R10"); idle(); rst_req = 1; rst_code = 12'h020;
        tick("R10"); idle();
        // Random mix against the model
        for (int n = 0; n < 400; n++) begin
            tick("R9"); idle();
            rst_req = ($urandom % 40) == 0; exc_req = ($urandom % 6) == 0; irq_req = ($urandom % 4) == 0;
            exc_kind = 2'($urandom); exc_code = 12'($urandom); irq_code = 12'($urandom);
            rst_code = 12'($urandom); trap_imm = 8'($urandom); in_dslot = 1'($urandom);
            cur_pc = $urandom & 32'hFFFF_FFFE; cur_r15 = $urandom;
            sr_we = ($urandom % 3) == 0; sr_wdata = $urandom & 32'h7000_80F3;
            vbr_we = ($urandom % 8) == 0; vbr_wdata = $urandom & 32'hFFFF_FF00;
            gr_we = 1'($urandom); gr_widx = 3'($urandom); gr_wdata = $urandom; gr_ridx = 3'($urandom);
        end
        tick("R9"); idle();
        tick("R9");
        @(negedge clk); #2;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule